// File: doc/BRIEF.md
# General-Purpose Register File with Same-Cycle Write Forwarding

This block holds the integer registers of a five-stage in-order processor. The decode stage reads two source operands through two independent address ports. The write-back stage stores one result per cycle through a single write port.

Both stages use the file in the same clock cycle, but they belong to different instructions. A decode-stage read can therefore name the register that write-back is updating in that same cycle. In that case the block sends the incoming write value straight to the read output, so decode sees the fresh result without a stall and without an extra forwarding path in the pipeline.

Register 0 is hard-wired to zero. A synchronous active-high reset clears every register.

Top module: `gpr_file`

## Requirements
- R1: While `rst` is high at a rising edge, every register becomes zero. After reset, reads of any index return 0 until a write lands.
- R2: When `wr_en` is 1 at a rising edge and `wr_idx` is nonzero, `wr_val` is stored in register `wr_idx`. From the next cycle on, both read ports return that value for that index.
- R3: When `wr_en` is 0 at a rising edge, no register changes.
- R4: When `wr_en` is 1, `wr_idx` is nonzero and `wr_idx` equals `rd_idx_a`, `rd_val_a` equals `wr_val` in that same cycle, not the stored value.
- R5: The forwarding check of port B is independent of port A. When both read indexes match a nonzero `wr_idx` with `wr_en` high, both outputs show `wr_val` at once.
- R6: A read port whose index differs from `wr_idx` returns the stored value even while the other port is being forwarded.
- R7: Index 0 always reads 0 on both ports. Writes to index 0 are discarded, and no forwarding happens for index 0.
- R8: Reads are combinational. A change of `rd_idx_a` or `rd_idx_b` shows on the output within the same cycle, with no clock edge.
- R9: With `wr_en` low, a matching `wr_idx` forwards nothing: the read port returns the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en | input | 1 | Write enable from write-back |
| wr_idx | input | 5 | Register index to write |
| wr_val | input | 32 | Value to write |
| rd_idx_a | input | 5 | Index for first source operand |
| rd_idx_b | input | 5 | Index for second source operand |
| rd_val_a | output | 32 | Value of register `rd_idx_a`, forwarded when it matches |
| rd_val_b | output | 32 | Value of register `rd_idx_b`, forwarded when it matches |

## Verification
The reads are tried under several conditions:
- A plain read of stored data shows that the storage and read path work with no write in flight.
- A match on port A only, on port B only, and on both ports together tells per-port forwarding apart from a shared decision.
- A matching index with the enable low separates forwarding that is gated by the enable from forwarding on the address alone.
- Writes and matching reads aimed at index 0 separate the hard-wired zero from ordinary storage.
- Changing the read index with no clock edge shows that the read path is combinational rather than registered.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_ADDR_W = 5;
  localparam int unsigned GPR_DATA_W = 32;
  localparam int unsigned GPR_NUM_RD = 2;
  localparam int unsigned GPR_DEPTH  = 1 << GPR_ADDR_W;
endpackage

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned ADDR_W = gpr_pkg::GPR_ADDR_W,
  parameter int unsigned DATA_W = gpr_pkg::GPR_DATA_W,
  parameter int unsigned NUM_RD = gpr_pkg::GPR_NUM_RD
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]              wr_val,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_raw
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_ok;

  // Entry 0 is never written, so it keeps its reset value of zero.
  assign wr_ok = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_idx] <= wr_val;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_raw[p] = mem[rd_idx[p]];
  end

  logic any_set;
  always_comb begin
    any_set = 1'b0;
    for (int i = 0; i < DEPTH; i++) any_set = any_set | (|mem[i]);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !any_set); // R1
  AST_ENTRY0_ZERO: assert property (@(posedge clk) disable iff (rst)
    mem[0] == '0); // R7
endmodule

// File: rtl/gpr_fwd.sv
module gpr_fwd #(
  parameter int unsigned ADDR_W = gpr_pkg::GPR_ADDR_W,
  parameter int unsigned DATA_W = gpr_pkg::GPR_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [ADDR_W-1:0] rd_idx,
  input  logic [DATA_W-1:0] rd_raw,
  output logic [DATA_W-1:0] rd_val
);
  logic hit;

  assign hit = wr_en && (wr_idx == rd_idx) && (rd_idx != '0);

  always_comb begin
    if (rd_idx == '0)  rd_val = '0;
    else if (hit)      rd_val = wr_val;
    else               rd_val = rd_raw;
  end

  AST_FWD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_idx && rd_idx != '0) |-> rd_val == wr_val); // R4
  AST_ZERO_IDX: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0) |-> rd_val == '0); // R7
  AST_NO_FWD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |-> rd_val == ((rd_idx == '0) ? '0 : rd_raw)); // R9
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned ADDR_W = gpr_pkg::GPR_ADDR_W,
  parameter int unsigned DATA_W = gpr_pkg::GPR_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [ADDR_W-1:0] rd_idx_a,
  input  logic [ADDR_W-1:0] rd_idx_b,
  output logic [DATA_W-1:0] rd_val_a,
  output logic [DATA_W-1:0] rd_val_b
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_RD-1:0][ADDR_W-1:0] rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_raw;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_val;

  assign rd_idx[0] = rd_idx_a;
  assign rd_idx[1] = rd_idx_b;
  assign rd_val_a  = rd_val[0];
  assign rd_val_b  = rd_val[1];

  gpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_val),
    .rd_idx (rd_idx),
    .rd_raw (rd_raw)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    gpr_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_val (wr_val),
      .rd_idx (rd_idx[p]),
      .rd_raw (rd_raw[p]),
      .rd_val (rd_val[p])
    );
  end

  // Set one cycle after reset is released, so that $past never reaches into reset.
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(wr_en) && $past(wr_idx) != '0 && $past(wr_idx) == rd_idx_a &&
     !(wr_en && wr_idx == rd_idx_a)) |-> rd_val_a == $past(wr_val)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (!$past(wr_en) && $stable(rd_idx_b) && !(wr_en && wr_idx == rd_idx_b))
      |-> $stable(rd_val_b)); // R3
  AST_PORT_B_FWD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && wr_idx == rd_idx_b) |-> rd_val_b == wr_val); // R5
endmodule

// File: tb/gpr_file_bench.sv
module gpr_file_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_val = '0;
  logic [4:0]  rd_idx_a = '0;
  logic [4:0]  rd_idx_b = '0;
  logic [31:0] rd_val_a;
  logic [31:0] rd_val_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpr_file u_gpr_file (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .rd_val_a(rd_val_a), .rd_val_b(rd_val_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Settle just after a rising edge; inputs change here, results are sampled 1 ns later.
  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [4:0] idx, input logic [31:0] val);
    wr_en = 1'b1; wr_idx = idx; wr_val = val;
    edge_wait();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rd_idx_a = 5'd7; rd_idx_b = 5'd31; #1;
    check("R1 reg7 after reset", rd_val_a, 32'h0);
    check("R1 reg31 after reset", rd_val_b, 32'h0);
  endtask

  task automatic t_write_read();
    do_write(5'd3, 32'hDEAD_0003);
    do_write(5'd31, 32'h1357_9BDF);
    rd_idx_a = 5'd3; rd_idx_b = 5'd31; #1;
    check("R2 port A reads reg3", rd_val_a, 32'hDEAD_0003);
    check("R2 port B reads reg31", rd_val_b, 32'h1357_9BDF);
    rd_idx_a = 5'd31; rd_idx_b = 5'd3; #1;
    check("R8 port A new index same cycle", rd_val_a, 32'h1357_9BDF);
    check("R8 port B new index same cycle", rd_val_b, 32'hDEAD_0003);
  endtask

  task automatic t_enable_low();
    wr_en = 1'b0; wr_idx = 5'd3; wr_val = 32'hBAD0_BAD0;
    rd_idx_a = 5'd3; rd_idx_b = 5'd9; #1;
    check("R9 no forward with enable low", rd_val_a, 32'hDEAD_0003);
    edge_wait();
    check("R3 reg3 unchanged after idle edge", rd_val_a, 32'hDEAD_0003);
    check("R3 reg9 unchanged after idle edge", rd_val_b, 32'h0);
  endtask

  task automatic t_fwd_a();
    rd_idx_a = 5'd3; rd_idx_b = 5'd31;
    wr_en = 1'b1; wr_idx = 5'd3; wr_val = 32'hA5A5_0033; #1;
    check("R4 port A forwarded", rd_val_a, 32'hA5A5_0033);
    check("R6 port B stored while A forwarded", rd_val_b, 32'h1357_9BDF);
    edge_wait();
    wr_en = 1'b0; #1;
    check("R2 forwarded write also stored", rd_val_a, 32'hA5A5_0033);
  endtask

  task automatic t_fwd_b_and_both();
    rd_idx_a = 5'd3; rd_idx_b = 5'd12;
    wr_en = 1'b1; wr_idx = 5'd12; wr_val = 32'h0C0C_1212; #1;
    check("R5 port B forwarded alone", rd_val_b, 32'h0C0C_1212);
    check("R6 port A stored while B forwarded", rd_val_a, 32'hA5A5_0033);
    edge_wait();
    rd_idx_a = 5'd20; rd_idx_b = 5'd20;
    wr_idx = 5'd20; wr_val = 32'h2020_F00D; #1;
    check("R5 both forwarded port A", rd_val_a, 32'h2020_F00D);
    check("R5 both forwarded port B", rd_val_b, 32'h2020_F00D);
    edge_wait();
    wr_en = 1'b0; rd_idx_a = 5'd12; #1;
    check("R2 reg12 stored", rd_val_a, 32'h0C0C_1212);
    check("R2 reg20 stored", rd_val_b, 32'h2020_F00D);
  endtask

  task automatic t_zero();
    rd_idx_a = 5'd0; rd_idx_b = 5'd0;
    wr_en = 1'b1; wr_idx = 5'd0; wr_val = 32'hFFFF_FFFF; #1;
    check("R7 no forward for index 0 port A", rd_val_a, 32'h0);
    check("R7 no forward for index 0 port B", rd_val_b, 32'h0);
    edge_wait();
    wr_en = 1'b0; #1;
    check("R7 write to index 0 discarded", rd_val_a, 32'h0);
  endtask

  task automatic t_overwrite();
    for (int k = 1; k < 32; k += 6) do_write(k[4:0], 32'h100 + k);
    for (int k = 1; k < 32; k += 6) begin
      rd_idx_a = k[4:0]; rd_idx_b = k[4:0]; #1;
      check("R2 sweep port A", rd_val_a, 32'h100 + k);
      check("R2 sweep port B", rd_val_b, 32'h100 + k);
    end
    rst = 1'b1; edge_wait(); rst = 1'b0;
    rd_idx_a = 5'd13; rd_idx_b = 5'd31; #1;
    check("R1 second reset clears reg13", rd_val_a, 32'h0);
    check("R1 second reset clears reg31", rd_val_b, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    edge_wait(); edge_wait();
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_enable_low();
    t_fwd_a();
    t_fwd_b_and_both();
    t_zero();
    t_overwrite();
    edge_wait();
    finish_run();
  end
endmodule